// File: doc/BRIEF.md
# Timer Channel Output Pin Controller

This block drives the output pins of a seven-channel timer array. Each channel has a one-bit output latch whose value is the pin level. The latch responds to single-cycle timer event pulses from the counters. In toggle mode, the channel's own event inverts the latch. In combination mode, the channel works as a slave: the event of a chosen master channel and the slave's own event act as set and reset. This is how PWM waveforms are built. A reset that arrives in the same cycle as a set always wins, which gives a clean 0% duty. A polarity bit swaps which of the two events sets the latch.

Each channel has a set of configuration bits: mode, polarity, output enable and master select. They are loaded together through one configuration write strobe.

The output-enable bit decides who owns the latch:
- While it is 1, only timer events reach the latch.
- While it is 0, events are blocked and a software data write loads the latch. This is how software places the pin at a known level before timing starts.

Software can read the latches at any time.

Top module: `tmr_pin_ctrl`

## Requirements
- R1: Synchronous active-low reset clears every output latch and every mode, polarity, enable and master-select bit to 0. Directly after reset, timer events leave the pins at 0.
- R2: With the mode bit at 0 (toggle) and the enable bit at 1, an event pulse on the channel's own input inverts its latch on the clock edge that samples the pulse. The polarity bit has no effect in this mode.
- R3: With the mode bit at 1 and polarity 0, the selected master's event sets the latch to 1, and the channel's own (slave) event clears it to 0.
- R4: With the mode bit at 1 and polarity 1, the roles swap: the master event clears the latch and the slave event sets it.
- R5: When the set and reset events of a combination-mode channel arrive in the same cycle, the latch goes to 0, whatever the polarity.
- R6: While a channel's enable bit is 1, a software data write leaves its latch unchanged.
- R7: While a channel's enable bit is 0, timer events leave its latch unchanged. A software data write loads bit c of the write data into the latch of channel c, and only that latch.
- R8: The read data port equals the current pin levels in every cycle, for either value of the enable bits.
- R9: The master select of channel c is a 3-bit field at bits [3c+2:3c] of the select bus. It names the channel whose event feeds channel c's combination logic. Events of other channels do not act on channel c in combination mode.
- R10: A channel in combination mode must have a master select that names a channel in {0, 2, 4} with an index below its own. Any other pairing is a configuration error.
- R11: A configuration write takes effect from the cycle after its strobe. An event sampled on the same edge as the strobe is handled with the previous configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_i | input | 7 | Per-channel timer event pulses, one cycle wide |
| cfg_we_i | input | 1 | Loads all configuration fields below |
| cfg_mode_i | input | 7 | Mode per channel: 0 toggle, 1 combination |
| cfg_pol_i | input | 7 | Polarity per channel: 1 swaps set and reset |
| cfg_oen_i | input | 7 | Output enable per channel: 1 events own the latch |
| cfg_msel_i | input | 21 | Master channel index per channel, 3 bits each |
| sw_we_i | input | 1 | Software data write strobe |
| sw_wdata_i | input | 7 | Software data, bit c for channel c |
| pin_o | output | 7 | Output pin levels |
| rd_data_o | output | 7 | Software read of the output latches |

## Verification
The bench builds the block with its default parameters: seven channels, with channels 0, 2 and 4 allowed as masters.

These defaults bring the following cases within reach:
- A slave paired with the lowest master (channel 1 on 0).
- Two slaves paired with different higher masters (channel 5 on 4, channel 6 on 2).
- A master that toggles its own pin while it drives a slave.

The directed scenarios exercise both polarities, the same-cycle set and reset collision, and the hand-over between software and event ownership, including an event that lands on the same edge as a configuration change.

// File: rtl/tmr_pin_pkg.sv
// Shared helpers for the timer output pin controller.
// Assumes channel indices fit the select field width chosen by the top.
package tmr_pin_pkg;

    // Kind of update a latch receives in one cycle.
    typedef enum logic [1:0] {
        UPD_NONE = 2'd0,
        UPD_SET  = 2'd1,
        UPD_CLR  = 2'd2,
        UPD_TGL  = 2'd3
    } upd_kind_e;

    // True when master index m may drive slave channel c under mask mm.
    function automatic logic pair_ok(input int m, input int c, input logic [31:0] mm);
        return (m < c) && (m >= 0) && mm[m];
    endfunction

endpackage

// File: rtl/tmr_pin_cfg.sv
// Configuration register bank: mode, polarity, enable and master select
// for every channel, all loaded together on one write strobe.
// Assumes software only loads legal master pairings for combination mode.
module tmr_pin_cfg #(
    parameter int N_CH = 7,
    parameter int SELW = 3,
    parameter logic [N_CH-1:0] MASTER_MASK = 7'b0010101
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 we_i,
    input  logic [N_CH-1:0]      mode_i,
    input  logic [N_CH-1:0]      pol_i,
    input  logic [N_CH-1:0]      oen_i,
    input  logic [N_CH*SELW-1:0] msel_i,
    output logic [N_CH-1:0]      mode_q,
    output logic [N_CH-1:0]      pol_q,
    output logic [N_CH-1:0]      oen_q,
    output logic [N_CH*SELW-1:0] msel_q
);

    // Hold the configuration; cleared on reset, replaced on each strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= '0;
            pol_q  <= '0;
            oen_q  <= '0;
            msel_q <= '0;
        end else if (we_i) begin
            mode_q <= mode_i;
            pol_q  <= pol_i;
            oen_q  <= oen_i;
            msel_q <= msel_i;
        end
    end

    for (genvar c = 0; c < N_CH; c++) begin : g_chk
        // R10: a combination-mode channel must point at a legal lower master.
        a_r10_legal_pair: assert property (@(posedge clk) disable iff (!rst_n)
            mode_q[c] |-> tmr_pin_pkg::pair_ok(int'(msel_q[c*SELW +: SELW]), c,
                                               32'(MASTER_MASK)));
    end

endmodule

// File: rtl/tmr_pin_route.sv
// Event router for one channel: turns its own event and the selected
// master's event into a set, clear or toggle request.
// Assumes events are single-cycle pulses; the clear beats the set.
module tmr_pin_route #(
    parameter int N_CH = 7,
    parameter int SELW = 3,
    parameter int CH   = 0
) (
    input  logic [N_CH-1:0]  evt_i,
    input  logic             mode_i,
    input  logic             pol_i,
    input  logic [SELW-1:0]  msel_i,
    output tmr_pin_pkg::upd_kind_e upd_o
);
    import tmr_pin_pkg::*;

    logic mst_evt;
    logic slv_evt;
    logic set_req;
    logic clr_req;

    // Pick the master's event; out-of-range selects give no event.
    always_comb begin
        mst_evt = 1'b0;
        for (int k = 0; k < N_CH; k++) begin
            if (int'(msel_i) == k) mst_evt = evt_i[k];
        end
        slv_evt = evt_i[CH];
    end

    // Map events to a request; the polarity swaps set and clear.
    always_comb begin
        set_req = pol_i ? slv_evt : mst_evt;
        clr_req = pol_i ? mst_evt : slv_evt;
        if (!mode_i)
            upd_o = slv_evt ? UPD_TGL : UPD_NONE;
        else if (clr_req)
            upd_o = UPD_CLR;
        else if (set_req)
            upd_o = UPD_SET;
        else
            upd_o = UPD_NONE;
    end

endmodule

// File: rtl/tmr_pin_latch.sv
// Output latch for one channel. The enable bit decides ownership:
// timer requests when set, software writes when clear.
// Assumes the request arrives already prioritised by the router.
module tmr_pin_latch (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   oen_i,
    input  tmr_pin_pkg::upd_kind_e upd_i,
    input  logic                   we_i,
    input  logic                   wd_i,
    output logic                   q_o
);
    import tmr_pin_pkg::*;

    // Update the pin level from the current owner of the latch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_o <= 1'b0;
        end else if (oen_i) begin
            unique case (upd_i)
                UPD_SET:  q_o <= 1'b1;
                UPD_CLR:  q_o <= 1'b0;
                UPD_TGL:  q_o <= ~q_o;
                default:  q_o <= q_o;
            endcase
        end else if (we_i) begin
            q_o <= wd_i;
        end
    end

    // R6: with events owning the latch and no request, the level holds.
    a_r6_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (oen_i && upd_i == UPD_NONE) |=> $stable(q_o));
    // R7: with software owning the latch and no write, the level holds.
    a_r7_events_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        (!oen_i && !we_i) |=> $stable(q_o));
    // R7: a software write is loaded when events do not own the latch.
    a_r7_sw_load: assert property (@(posedge clk) disable iff (!rst_n)
        (!oen_i && we_i) |=> (q_o == $past(wd_i)));
    // R2: a toggle request inverts the level.
    a_r2_toggle: assert property (@(posedge clk) disable iff (!rst_n)
        (oen_i && upd_i == UPD_TGL) |=> (q_o != $past(q_o)));
    // R5: a clear request drives the level low.
    a_r5_clear_low: assert property (@(posedge clk) disable iff (!rst_n)
        (oen_i && upd_i == UPD_CLR) |=> !q_o);
    // R3: a set request drives the level high.
    a_r3_set_high: assert property (@(posedge clk) disable iff (!rst_n)
        (oen_i && upd_i == UPD_SET) |=> q_o);

endmodule

// File: rtl/tmr_pin_ctrl.sv
// Top of the timer output pin controller: configuration bank, one event
// router and one output latch per channel, and the software read path.
// Assumes events are single-cycle pulses synchronous to clk.
module tmr_pin_ctrl #(
    parameter int N_CH = 7,
    parameter logic [N_CH-1:0] MASTER_MASK = 7'b0010101,
    localparam int SELW = $clog2(N_CH)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [N_CH-1:0]      evt_i,
    input  logic                 cfg_we_i,
    input  logic [N_CH-1:0]      cfg_mode_i,
    input  logic [N_CH-1:0]      cfg_pol_i,
    input  logic [N_CH-1:0]      cfg_oen_i,
    input  logic [N_CH*SELW-1:0] cfg_msel_i,
    input  logic                 sw_we_i,
    input  logic [N_CH-1:0]      sw_wdata_i,
    output logic [N_CH-1:0]      pin_o,
    output logic [N_CH-1:0]      rd_data_o
);

    logic [N_CH-1:0]      mode_q;
    logic [N_CH-1:0]      pol_q;
    logic [N_CH-1:0]      oen_q;
    logic [N_CH*SELW-1:0] msel_q;
    logic [N_CH-1:0]      lat_q;

    tmr_pin_cfg #(
        .N_CH(N_CH), .SELW(SELW), .MASTER_MASK(MASTER_MASK)
    ) u_cfg (
        .clk(clk), .rst_n(rst_n), .we_i(cfg_we_i),
        .mode_i(cfg_mode_i), .pol_i(cfg_pol_i), .oen_i(cfg_oen_i), .msel_i(cfg_msel_i),
        .mode_q(mode_q), .pol_q(pol_q), .oen_q(oen_q), .msel_q(msel_q)
    );

    for (genvar c = 0; c < N_CH; c++) begin : g_ch
        tmr_pin_pkg::upd_kind_e upd;

        tmr_pin_route #(.N_CH(N_CH), .SELW(SELW), .CH(c)) u_route (
            .evt_i(evt_i), .mode_i(mode_q[c]), .pol_i(pol_q[c]),
            .msel_i(msel_q[c*SELW +: SELW]), .upd_o(upd)
        );

        tmr_pin_latch u_latch (
            .clk(clk), .rst_n(rst_n), .oen_i(oen_q[c]), .upd_i(upd),
            .we_i(sw_we_i), .wd_i(sw_wdata_i[c]), .q_o(lat_q[c])
        );
    end

    // Drive the pins and the read path from the same latches.
    always_comb begin
        pin_o     = lat_q;
        rd_data_o = lat_q;
    end

endmodule

// File: tb/sim_tmr_pin_ctrl.sv
module sim_tmr_pin_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [6:0]  evt = '0;
    logic        cfg_we = 1'b0;
    logic [6:0]  cfg_mode = '0, cfg_pol = '0, cfg_oen = '0;
    logic [20:0] cfg_msel = '0;
    logic        sw_we = 1'b0;
    logic [6:0]  sw_wdata = '0;
    logic [6:0]  pin, rd;
    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    tmr_pin_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .evt_i(evt), .cfg_we_i(cfg_we),
        .cfg_mode_i(cfg_mode), .cfg_pol_i(cfg_pol), .cfg_oen_i(cfg_oen),
        .cfg_msel_i(cfg_msel), .sw_we_i(sw_we), .sw_wdata_i(sw_wdata),
        .pin_o(pin), .rd_data_o(rd)
    );

    task automatic chk(input string tag, input logic [6:0] exp);
        checks++;
        if (pin !== exp) begin
            errors++;
            $display("FAIL %s: pin=%b expected=%b", tag, pin, exp);
        end
        checks++;
        if (rd !== pin) begin
            errors++;
            $display("FAIL R8: rd=%b expected=%b", rd, pin);
        end
    endtask

    function automatic logic [20:0] sel(input int c, input int m);
        logic [20:0] v = '0;
        v[c*3 +: 3] = 3'(m);
        return v;
    endfunction

    task automatic cfg(input logic [6:0] md, input logic [6:0] pl,
                       input logic [6:0] oe, input logic [20:0] ms);
        @(negedge clk);
        cfg_we = 1; cfg_mode = md; cfg_pol = pl; cfg_oen = oe; cfg_msel = ms;
        @(negedge clk);
        cfg_we = 0;
    endtask

    task automatic pulse(input logic [6:0] e);
        @(negedge clk); evt = e;
        @(negedge clk); evt = '0;
    endtask

    task automatic swr(input logic [6:0] d);
        @(negedge clk); sw_we = 1; sw_wdata = d;
        @(negedge clk); sw_we = 0;
    endtask

    task automatic init_pins(input logic [6:0] v);
        cfg('0, '0, '0, '0);
        swr(v);
        chk("R7 sw load", v);
    endtask

    task automatic t_reset;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R1 reset pins", 7'b0);
        pulse(7'h7f);
        chk("R1 events after reset ignored", 7'b0);
    endtask

    task automatic t_sw_and_toggle;
        init_pins(7'b1010101);
        pulse(7'h7f);
        chk("R7 events blocked", 7'b1010101);
        cfg('0, 7'h7f, 7'h7f, '0);
        swr(7'b0);
        chk("R6 write ignored", 7'b1010101);
        pulse(7'b0000011);
        chk("R2 toggle with pol ignored", 7'b1010110);
        // R11: event on the same edge as a config change uses old config
        @(negedge clk);
        cfg_we = 1; cfg_mode = '0; cfg_pol = '0; cfg_oen = '0; cfg_msel = '0;
        evt = 7'b0000001;
        @(negedge clk);
        cfg_we = 0; evt = '0;
        chk("R11 old config applies", 7'b1010111);
        pulse(7'b0000001);
        chk("R11 new config applies", 7'b1010111);
    endtask

    task automatic t_comb_pol0;
        init_pins(7'b0);
        cfg(7'b0000010, '0, 7'h7f, sel(1, 0));
        pulse(7'b0000001);
        chk("R3 master sets", 7'b0000011);
        pulse(7'b0000010);
        chk("R3 slave resets", 7'b0000001);
    endtask

    task automatic t_comb_pol1;
        init_pins(7'b0);
        cfg(7'b0000010, 7'b0000010, 7'h7f, sel(1, 0));
        pulse(7'b0000001);
        chk("R4 master resets", 7'b0000001);
        pulse(7'b0000010);
        chk("R4 slave sets", 7'b0000011);
        pulse(7'b0000001);
        chk("R4 master resets again", 7'b0000000);
    endtask

    task automatic t_collision;
        init_pins(7'b0);
        cfg(7'b0000010, '0, 7'h7f, sel(1, 0));
        pulse(7'b0000001);
        chk("R5 pre-set pol0", 7'b0000011);
        pulse(7'b0000011);
        chk("R5 reset wins pol0", 7'b0000000);
        init_pins(7'b0);
        cfg(7'b0000010, 7'b0000010, 7'h7f, sel(1, 0));
        pulse(7'b0000010);
        chk("R5 pre-set pol1", 7'b0000010);
        pulse(7'b0000011);
        chk("R5 reset wins pol1", 7'b0000001);
    endtask

    task automatic t_routing;
        // R10: only legal pairs are used (5 on 4, 6 on 2)
        init_pins(7'b0);
        cfg(7'b1100000, '0, 7'h7f, sel(5, 4) | sel(6, 2));
        pulse(7'b0010000);
        chk("R9 master 4 sets ch5 only", 7'b0110000);
        pulse(7'b0000100);
        chk("R9 master 2 sets ch6 only", 7'b1110100);
        pulse(7'b1000000);
        chk("R9 slave 6 resets", 7'b0110100);
        pulse(7'b0100000);
        chk("R9 slave 5 resets", 7'b0010100);
    endtask

    initial begin
        t_reset();
        t_sw_and_toggle();
        t_comb_pol0();
        t_comb_pol1();
        t_collision();
        t_routing();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule